// File: doc/BRIEF.md
# Power-Fail Interrupt Glitch Filter

This block turns a raw, noisy power-fail comparator flag into a clean, active-low early-warning interrupt for a processor. The analog sense comparator, its reference and its divider sit outside the block. The block receives three digital flags:

- the input is below the trip level;
- the main supply has reached its good threshold;
- the main supply has dropped below the battery level.

A one-cycle sample tick from an external divider, at about 30 kHz (a period of about 33 µs), sets the pace of filtering.

Noise is rejected in the time domain. The interrupt asserts only after a run of consecutive below-trip samples, three by default. Any sample at or above the trip level breaks the run, and it also releases an interrupt that is already asserted. While the supply is not yet good, the run counter is held at zero, so no detection can reach the pin during power-up. When the supply falls below the battery level, the output enable drops and the pin floats.

The interface is plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pfi_glitch_filter`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) sets `irq_n` to 1 and `irq_oe` to 1, and clears the run count, so that a fresh run of `RUN_LEN` samples is needed after reset.
- R2: With `supply_good` at 1, `irq_n` goes to 0 at the clock edge that samples the `RUN_LEN`-th consecutive tick with `below_trip` at 1 (`RUN_LEN` defaults to 3). Further below-trip ticks keep it at 0.
- R3: A tick with `below_trip` at 0 clears the run count. A run that is broken before its `RUN_LEN`-th sample does not assert `irq_n`.
- R4: In cycles where `sample_tick` is 0, the run count and `irq_n` do not change, whatever `below_trip` does.
- R5: While `supply_good` is 0, the run count is held at 0 and `irq_n` cannot fall. An interrupt that is already asserted stays asserted.
- R6: A tick with `below_trip` at 0 sets `irq_n` back to 1 at that clock edge. This holds whatever the value of `supply_good`.
- R7: `irq_oe` equals the inverse of `below_battery` as sampled at the previous clock edge (one cycle of latency). It is 0 while the supply is under the battery level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle sample enable, about 30 kHz |
| below_trip | input | 1 | Comparator flag: monitored input is below the trip level |
| supply_good | input | 1 | Main supply has reached its good threshold |
| below_battery | input | 1 | Main supply is below the battery level |
| irq_n | output | 1 | Active-low power-fail interrupt |
| irq_oe | output | 1 | Output enable for the interrupt pin (0 means high impedance) |

## Verification
The bench targets the following cases, each of which a faulty design would get wrong in a visible way:

- **Run one sample short.** The bench breaks a run after two low samples and then starts a new one. A counter that does not clear would fire early.
- **Off-by-one threshold.** A run-length comparison off by one would fire on the second tick or on the fourth.
- **Power-up gating.** The bench gives low samples while the supply is not good, then gives two more after the supply comes good. A design that keeps stale counts would assert after those two.
- **Release.** The bench checks that release happens on the first high sample even with the supply not good.
- **Idle cycles and reset.** Idle cycles between ticks must not advance the count, and a reset in the middle of an assertion must clear both the pin and the run.
- **Output enable.** The bench checks the one-cycle latency of the output enable.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  // Classification of one clock cycle of comparator input
  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,   // no sample tick this cycle
    EV_LOW  = 2'd1,   // sampled below the trip level
    EV_HIGH = 2'd2    // sampled at or above the trip level
  } sample_ev_t;

  localparam int unsigned DEFAULT_RUN_LEN = 3;
endpackage

// File: rtl/pfi_run_counter.sv
module pfi_run_counter
  import pfi_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEFAULT_RUN_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  sample_ev_t ev,
  input  logic       gate_ok,
  output logic       run_hit
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !gate_ok || ev == EV_HIGH) begin
      cnt_q <= '0;
    end else if (ev == EV_LOW && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // The current low sample completes a run
  assign run_hit = (ev == EV_LOW) && gate_ok && (cnt_q >= LAST);

  // R3: a high sample empties the run
  p_high_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HIGH) |=> (cnt_q == '0));
  // R4: no tick, no count change
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_IDLE && gate_ok) |=> $stable(cnt_q));
  // R5: supply not good keeps the count at zero
  p_gate_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !gate_ok |=> (cnt_q == '0));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);
endmodule

// File: rtl/pfi_irq_latch.sv
module pfi_irq_latch
  import pfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sample_ev_t ev,
  input  logic       run_hit,
  output logic       irq_n
);
  always_ff @(posedge clk) begin
    if (rst)                 irq_n <= 1'b1;
    else if (ev == EV_HIGH)  irq_n <= 1'b1;
    else if (run_hit)        irq_n <= 1'b0;
  end

  // R6: a high sample releases the interrupt
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HIGH) |=> irq_n);
  // R2: assertion only follows a low sample
  p_fall_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(ev == EV_LOW));
endmodule

// File: rtl/pfi_oe_reg.sv
module pfi_oe_reg (
  input  logic clk,
  input  logic rst,
  input  logic below_battery,
  output logic irq_oe
);
  always_ff @(posedge clk) begin
    if (rst) irq_oe <= 1'b1;
    else     irq_oe <= !below_battery;
  end

  // R7: output floats one cycle after the supply drops under battery
  p_float_r7: assert property (@(posedge clk) disable iff (rst)
    below_battery |=> !irq_oe);
endmodule

// File: rtl/pfi_glitch_filter.sv
module pfi_glitch_filter
  import pfi_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEFAULT_RUN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_tick,
  input  logic below_trip,
  input  logic supply_good,
  input  logic below_battery,
  output logic irq_n,
  output logic irq_oe
);
  sample_ev_t ev;
  logic       run_hit;

  always_comb begin
    if (!sample_tick)    ev = EV_IDLE;
    else if (below_trip) ev = EV_LOW;
    else                 ev = EV_HIGH;
  end

  pfi_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .gate_ok (supply_good),
    .run_hit (run_hit)
  );

  pfi_irq_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .run_hit (run_hit),
    .irq_n   (irq_n)
  );

  pfi_oe_reg u_oe (
    .clk           (clk),
    .rst           (rst),
    .below_battery (below_battery),
    .irq_oe        (irq_oe)
  );

  // R1: reset leaves the pin released and driven
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (irq_n && irq_oe));
  // R5: supply not good blocks a new assertion
  p_gate_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    !supply_good |=> !$fell(irq_n));
  // R4: without a tick the pin holds
  p_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_tick |=> $stable(irq_n));
endmodule

// File: tb/sim_pfi_glitch_filter.sv
module sim_pfi_glitch_filter;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, sample_tick, below_trip, supply_good, below_battery;
  logic irq_n, irq_oe;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pfi_glitch_filter u0 (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .below_trip(below_trip),
    .supply_good(supply_good), .below_battery(below_battery),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  // Each entry: {below_trip, supply_good, expected irq_n after the tick}
  localparam int NV = 15;
  localparam logic [2:0] VEC [NV] = '{
    3'b111,  // R2 run 1
    3'b111,  // R2 run 2
    3'b011,  // R3 break before third
    3'b111,  // R3 new run 1
    3'b111,  // run 2
    3'b110,  // R2 third low asserts
    3'b110,  // R2 stays asserted
    3'b011,  // R6 release
    3'b101,  // R5 gated
    3'b101,  // R5 gated
    3'b111,  // R5 run restarts from zero
    3'b111,  // run 2
    3'b110,  // R2 asserts
    3'b100,  // R5 held while not good
    3'b001   // R6 release while not good
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input logic bt, input logic sg);
    below_trip  = bt;
    supply_good = sg;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
  endtask

  task automatic idle(input int n, input logic bt);
    below_trip = bt;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; sample_tick = 1'b0; below_trip = 1'b0;
    supply_good = 1'b1; below_battery = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 irq_n after reset", irq_n, 1'b1);
    check("R1 irq_oe after reset", irq_oe, 1'b1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][2], VEC[i][1]);
      check($sformatf("R2/R3/R5/R6 vector %0d", i), irq_n, VEC[i][0]);
      idle(2, 1'b0);
    end

    // R4: idle cycles with the input low do not advance the run
    supply_good = 1'b1;
    idle(20, 1'b1);
    check("R4 no tick no assert", irq_n, 1'b1);
    tick(1'b1, 1'b1); idle(15, 1'b1);
    tick(1'b1, 1'b1); idle(15, 1'b0);
    check("R4 two ticks separated by idle", irq_n, 1'b1);
    tick(1'b1, 1'b1);
    check("R4 third tick after idle asserts", irq_n, 1'b0);
    idle(10, 1'b0);
    check("R4 idle high input keeps assertion", irq_n, 1'b0);

    // R1: reset mid-assertion clears pin and run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset releases irq_n", irq_n, 1'b1);
    tick(1'b1, 1'b1); tick(1'b1, 1'b1);
    check("R1 run cleared by reset", irq_n, 1'b1);
    tick(1'b1, 1'b1);
    check("R2 assert after fresh run", irq_n, 1'b0);
    tick(1'b0, 1'b1);
    check("R6 release", irq_n, 1'b1);

    // R7: output enable follows below_battery with one cycle latency
    below_battery = 1'b1;
    #1;
    check("R7 oe before edge", irq_oe, 1'b1);
    @(negedge clk);
    check("R7 oe drops", irq_oe, 1'b0);
    below_battery = 1'b0;
    @(negedge clk);
    check("R7 oe returns", irq_oe, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule